// File: doc/BRIEF.md
# Stop mode power controller

This block puts a small microcontroller into its deepest standby state and brings it back. Software has to unlock a key register with two writes in a fixed order. It then sets a stop-request bit in a control register. In stop, both oscillator enables drop and every clock gate closes. A non-maskable interrupt, or an enabled request on one of the port interrupt pins, starts the wake-up.

On wake the low-speed oscillator is enabled again. The high-speed oscillator is enabled again only if software had it on before stop. The clock gates stay closed while a parameterised start delay runs, and then while a settling window of low-speed ticks runs. Both are counted on a tick input that stands for the low-speed oscillator. When the count ends, the low-speed gate reopens and the block returns to run. The high-speed gate opens at the same moment if that oscillator reports ready.

The bus is a simple single-cycle register port with two addresses. A 2-bit status output gives the current mode.

Top module: `stop_ctl`

## Requirements
- R1: After reset the block is in run mode (`mode` = 0), `ls_osc_en` = 1, `hs_osc_en` = 0, `ls_clk_en` = 1 and `hs_clk_en` = 0. Both registers read back as 0.
- R2: Reading address 0 returns the unlock state in bit 0 (1 = armed). The key is armed by a write to address 0 with upper nibble 0x5, followed immediately, among writes to address 0, by a write with upper nibble 0xA. The lower nibbles of both writes are ignored.
- R3: Any other write to address 0 leaves the key unarmed. A write with upper nibble 0x5 always restarts the sequence, even when the key is half-way through or already armed.
- R4: Address 1 holds the stop-request bit in bit 0 and the high-speed oscillator enable in bit 1. Writing bit 0 = 1 while the key is armed enters stop mode (`mode` = 1). Writing it while the key is not armed has no effect on the mode, and bit 0 reads back 0. Bit 1 is always written.
- R5: Entering stop disarms the key. A later stop request needs a new unlock sequence.
- R6: In stop mode `ls_osc_en`, `hs_osc_en`, `ls_clk_en` and `hs_clk_en` are all 0. Bus writes are ignored whenever the block is not in run mode.
- R7: In stop mode, the block leaves stop when `nmi_req` is 1, or when `port_irq[i]` and `port_ie[i]` are both 1 for some i. Masked requests and `ls_tick` pulses do not wake it.
- R8: On the cycle that wake is seen, the block enters the waking mode (`mode` = 2) and clears the stop-request bit. It drives `ls_osc_en` = 1, and `hs_osc_en` equal to the high-speed enable bit that was set before stop.
- R9: In the waking mode `ls_clk_en` stays 0 until START_DLY + SETTLE_EDGES `ls_tick` pulses have been sampled in that mode. On the clock edge that samples the last of them, the block returns to run mode and `ls_clk_en` becomes 1.
- R10: `hs_clk_en` is 1 exactly when the block is in run mode, the high-speed enable bit is 1 and `hs_ready` is 1. It therefore opens together with the low-speed gate at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 key, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ls_tick | input | 1 | One-cycle pulse per low-speed oscillator edge |
| hs_ready | input | 1 | High-speed oscillator is running and stable |
| nmi_req | input | 1 | Non-maskable interrupt request |
| port_irq | input | NPORT | Port pin interrupt requests |
| port_ie | input | NPORT | Port pin interrupt enable flags |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_clk_en | output | 1 | Low-speed clock gate to CPU and peripherals |
| hs_clk_en | output | 1 | High-speed clock gates |
| mode | output | 2 | 0 run, 1 stopped, 2 waking |

## Verification
The assertions check the following on every cycle:
- stop is entered only from an armed key, and entry always disarms it;
- a stopped block stays stopped without an unmasked request and leaves it on the edge after one;
- release from waking comes only after exactly the full tick count;
- the high-speed gate is never open without the low-speed gate.

The bench's sweeps cover what a property cannot see. It crosses every pair of key nibbles, every mask and request pattern with and without the NMI, and both high-speed settings. It shows that stray key writes during stop leave nothing armed after release, and that a second stop request without a new unlock is refused.

// File: rtl/stop_ctl.sv
`timescale 1ns/100ps
module stop_ctl #(
  parameter int START_DLY    = 32,
  parameter int SETTLE_EDGES = 8192,
  parameter int NPORT        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             ls_tick,
  input  logic             hs_ready,
  input  logic             nmi_req,
  input  logic [NPORT-1:0] port_irq,
  input  logic [NPORT-1:0] port_ie,
  output logic             ls_osc_en,
  output logic             hs_osc_en,
  output logic             ls_clk_en,
  output logic             hs_clk_en,
  output logic [1:0]       mode
);
  localparam int TOTAL = START_DLY + SETTLE_EDGES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [1:0] M_RUN = 2'd0, M_STOP = 2'd1, M_WAKE = 2'd2;
  localparam logic [1:0] K_IDLE = 2'd0, K_HALF = 2'd1, K_ARMED = 2'd2;

  logic [1:0]    mode_q, key_q;
  logic          stp_q, hs_on_q;
  logic [CW-1:0] cnt_q;

  wire run       = (mode_q == M_RUN);
  wire key_wr    = bus_we & run & ~bus_addr;
  wire ctl_wr    = bus_we & run & bus_addr;
  wire armed     = (key_q == K_ARMED);
  wire go_stop   = ctl_wr & bus_wdata[0] & armed;
  wire wake      = nmi_req | (|(port_irq & port_ie));
  wire last_tick = ls_tick & (cnt_q == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      key_q <= K_IDLE;
    else if (go_stop)
      key_q <= K_IDLE;
    else if (key_wr) begin
      if (bus_wdata[7:4] == 4'h5)
        key_q <= K_HALF;
      else if (key_q == K_HALF && bus_wdata[7:4] == 4'hA)
        key_q <= K_ARMED;
      else
        key_q <= K_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      stp_q  <= 1'b0;
    end else begin
      case (mode_q)
        M_RUN:  if (go_stop) begin mode_q <= M_STOP; stp_q <= 1'b1; end
        M_STOP: if (wake)    begin mode_q <= M_WAKE; stp_q <= 1'b0; end
        M_WAKE: if (last_tick) mode_q <= M_RUN;
        default: mode_q <= M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hs_on_q <= 1'b0;
    else if (ctl_wr)
      hs_on_q <= bus_wdata[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_q != M_WAKE)
      cnt_q <= '0;
    else if (ls_tick)
      cnt_q <= cnt_q + 1'b1;
  end

  assign bus_rdata = bus_addr ? {6'b0, hs_on_q, stp_q} : {7'b0, armed};
  assign ls_osc_en = (mode_q != M_STOP);
  assign hs_osc_en = hs_on_q & (mode_q != M_STOP);
  assign ls_clk_en = run;
  assign hs_clk_en = run & hs_on_q & hs_ready;
  assign mode      = mode_q;
endmodule

// File: rtl/stop_ctl_chk.sv
`timescale 1ns/100ps
module stop_ctl_chk #(
  parameter int TOTAL = 8,
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_q,
  input logic [1:0]       key_q,
  input logic             ls_tick,
  input logic             nmi_req,
  input logic [NPORT-1:0] port_irq,
  input logic [NPORT-1:0] port_ie,
  input logic             ls_clk_en,
  input logic             hs_clk_en
);
  int unsigned seen;
  wire req = nmi_req | (|(port_irq & port_ie));

  always_ff @(posedge clk) begin
    if (!rst_n || mode_q == 2'd1)
      seen <= 0;
    else if (mode_q == 2'd2 && ls_tick)
      seen <= seen + 1;
  end

  // R4
  stop_entry_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && $past(mode_q) == 2'd0) |-> $past(key_q) == 2'd2);
  // R5
  stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && $past(mode_q) == 2'd0) |-> key_q == 2'd0);
  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && !req) |=> mode_q == 2'd1);
  // R7
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && req) |=> mode_q == 2'd2);
  // R9
  wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'd2 |-> (seen < TOTAL && !ls_clk_en));
  // R9
  release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'd2 && mode_q == 2'd0) |-> seen == TOTAL);
  // R10
  hs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_clk_en |-> ls_clk_en);
endmodule

bind stop_ctl stop_ctl_chk #(.TOTAL(START_DLY + SETTLE_EDGES), .NPORT(NPORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .key_q(key_q), .ls_tick(ls_tick),
  .nmi_req(nmi_req), .port_irq(port_irq), .port_ie(port_ie),
  .ls_clk_en(ls_clk_en), .hs_clk_en(hs_clk_en)
);

// File: tb/stop_ctl_tb_top.sv
`timescale 1ns/100ps
module stop_ctl_tb_top;
  localparam int DLY = 2, SET = 6, TOT = DLY + SET, NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_addr = 1'b0, ls_tick = 1'b0, hs_ready = 1'b0, nmi_req = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] port_irq = '0, port_ie = '0;
  logic ls_osc_en, hs_osc_en, ls_clk_en, hs_clk_en;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stop_ctl #(.START_DLY(DLY), .SETTLE_EDGES(SET), .NPORT(NP)) dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(bit a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); ls_tick = 1'b1;
    @(negedge clk); ls_tick = 1'b0;
  endtask

  task automatic unlock();
    wr(0, 8'h53); wr(0, 8'hAC);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 mode", mode, 0);
    check("R1 ls_osc_en", ls_osc_en, 1);
    check("R1 hs_osc_en", hs_osc_en, 0);
    check("R1 ls_clk_en", ls_clk_en, 1);
    check("R1 hs_clk_en", hs_clk_en, 0);
    rd(0, v); check("R1 key read", v, 0);
    rd(1, v); check("R1 ctl read", v, 0);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        wr(0, {4'(a), 4'(a + b)});
        wr(0, {4'(b), 4'(3 * a)});
        rd(0, v);
        check("R2 armed after nibble pair", v, (a == 5 && b == 10) ? 1 : 0);
        wr(0, 8'h00);
        rd(0, v); check("R3 disarm by other write", v, 0);
      end
    wr(0, 8'h51); wr(0, 8'h33); wr(0, 8'hA0); rd(0, v);
    check("R3 broken sequence", v, 0);
    wr(0, 8'h51); wr(0, 8'h5E); wr(0, 8'hA0); rd(0, v);
    check("R3 restart on repeated first byte", v, 1);
    wr(0, 8'h5F); rd(0, v);
    check("R3 first byte while armed restarts", v, 0);

    wr(0, 8'h00);
    wr(1, 8'h01);
    check("R4 unarmed stop ignored", mode, 0);
    rd(1, v); check("R4 STP reads 0 when refused", v, 0);
    wr(1, 8'h03);
    check("R4 unarmed stop ignored with hs bit", mode, 0);
    rd(1, v); check("R4 hs bit written", v, 2);

    for (int n = 0; n < 2; n++)
      for (int ie = 0; ie < 16; ie++)
        for (int irq = 0; irq < 16; irq++) begin
          bit hs, hsr, wk;
          hs  = 1'((ie + irq) & 1);
          hsr = 1'(irq >> 1) ^ 1'(n);
          wk  = (n == 1) || ((ie & irq) != 0);
          port_ie = 4'(ie);
          wr(1, {6'b0, hs, 1'b0});
          unlock();
          wr(1, {6'b0, hs, 1'b1});
          check("R4 stop entered", mode, 1);
          check("R6 ls_osc_en off", ls_osc_en, 0);
          check("R6 hs_osc_en off", hs_osc_en, 0);
          check("R6 gates closed", {ls_clk_en, hs_clk_en}, 0);
          wr(0, 8'h5F); wr(0, 8'hAF);
          tick(); tick();
          check("R7 ticks do not wake", mode, 1);
          @(negedge clk); nmi_req = 1'(n); port_irq = 4'(irq);
          @(negedge clk); nmi_req = 1'b0; port_irq = '0;
          check("R7 wake decision", mode, wk ? 2 : 1);
          if (!wk) begin
            @(negedge clk); nmi_req = 1'b1;
            @(negedge clk); nmi_req = 1'b0;
            check("R7 nmi wake", mode, 2);
          end
          check("R8 ls_osc_en back", ls_osc_en, 1);
          check("R8 hs_osc_en restored", hs_osc_en, hs);
          hs_ready = hsr;
          for (int t = 1; t < TOT; t++) tick();
          check("R9 still waking before last tick", mode, 2);
          check("R9 ls gate closed before last tick", ls_clk_en, 0);
          tick();
          check("R9 run after full count", mode, 0);
          check("R9 ls gate open", ls_clk_en, 1);
          check("R10 hs gate at release", hs_clk_en, hs & hsr);
          rd(0, v); check("R6 stop-time key writes ignored", v, 0);
          rd(1, v); check("R8 STP cleared", v, {30'b0, hs, 1'b0});
          wr(1, {6'b0, hs, 1'b1});
          check("R5 second stop needs unlock", mode, 0);
        end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule